// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Hardware Nesting

This block collects a set of level-style system interrupt lines. It latches a rising edge on each line into a status bit and assigns every line to a priority channel through a per-line map register. From these it drives two host interrupt lines toward a processor: a fast line fed by the highest-priority channels and a normal line fed by all the others. For each host, software reads an index register to learn which pending, enabled line wins. A lower channel number is more urgent, and among lines sharing a channel the lowest line index wins.

That index read doubles as the acknowledge. When automatic nesting is selected, the acknowledge raises a nesting level to the winner's channel. From then on only strictly more urgent channels can reach the host line, until the service routine writes the previous level back. Four nesting modes are available:

- Off: levels are ignored.
- Global: one level is shared by both hosts.
- Per host: a separate level for each host.
- Manual: one shared level that only software writes.

The block has no streaming data path, so there is no valid/ready handshake anywhere. All ports are plain control and status signals. The register port is a simple strobe interface: a write takes effect at the clock edge where `reg_wr_i` is high. A read returns data on `reg_rdata_o` one cycle after the edge where `reg_rd_i` is high. Neither can stall.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the following hold. All enables are 0 and the status register is 0. The mode field is 0 (nesting off). All three nesting levels read NUM_CHAN, every map register reads NUM_CHAN-1, and both host lines are low.
- R2: A rising edge on line i sets status bit i. A line held high does not set the bit again. Writing 1 to bit i of the status register (offset 2) clears that bit only, and 0 bits have no effect. The status bits do not depend on the enables.
- R3: A host line is high only while some line has both its status bit and its enable bit (offset 1) set, with an eligible channel. Channels below FAST_CHANS go to the fast line, and all others go to the normal line. The map register for line i sits at offset 16+i.
- R4: An index read returns the winning line: the one with the lowest channel number, and among equal channels the lowest index. The fast index is at offset 6 and the normal index is at offset 7.
- R5: An index read with no eligible line for that host returns 0x8000_0000.
- R6: Global mode is mode value 1 in bits [1:0] of offset 0. In this mode an index read that finds a winner sets the shared level (offset 3) to the winner's channel. Only lines whose channel is strictly below the level then drive either host line.
- R7: Per-host mode is mode value 2. In this mode an index read raises only its own host's level: fast at offset 4, normal at offset 5. The other host's level and output are untouched.
- R8: Manual mode is mode value 3. In this mode index reads never change any level, but the shared level written by software still masks both hosts.
- R9: Off mode is mode value 0. In this mode every level is ignored for masking and index reads change no level.
- R10: A software write to a level register takes effect at once and can lower the mask again, restoring lines that were blocked.
- R11: Read data appears on `reg_rdata_o` exactly one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | NUM_SRC | System interrupt lines, synchronous to clk_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (index reads acknowledge) |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |
| fast_irq_o | output | 1 | Fast host interrupt |
| norm_irq_o | output | 1 | Normal host interrupt |

## Verification
The bench builds the block with NUM_SRC=8, NUM_CHAN=4 and FAST_CHANS=2. With these values every level from 0 to the unmasked value 4 can be reached in a few writes. The values also give two channels per host, so channel ties, cross-host masking under the shared level, and per-host isolation can all be set up with a handful of lines. Each nesting mode is driven through acknowledge, mask and restore, and the results are checked only through the host lines and register reads.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    NEST_OFF     = 2'd0,
    NEST_GLOBAL  = 2'd1,
    NEST_PERHOST = 2'd2,
    NEST_MANUAL  = 2'd3
  } nest_mode_e;

  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_EN    = 1;
  localparam int unsigned OFS_STAT  = 2;
  localparam int unsigned OFS_GLVL  = 3;
  localparam int unsigned OFS_FLVL  = 4;
  localparam int unsigned OFS_NLVL  = 5;
  localparam int unsigned OFS_FIDX  = 6;
  localparam int unsigned OFS_NIDX  = 7;
  localparam int unsigned OFS_MAP   = 16;
endpackage

// File: rtl/irq_src_status.sv
`timescale 1ns/1ps
module irq_src_status #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] edge_set;

  assign edge_set = src_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= src_i;
      stat_q <= (stat_q & ~clr_i) | edge_set;
    end
  end

  assign status_o = stat_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    // R2
    edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(src_i[g]) |=> status_o[g]);
    // R2
    clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !edge_set[g]) |=> !status_o[g]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NUM_CHAN   = 16,
  parameter int unsigned FAST_CHANS = 2,
  parameter bit          FAST_HOST  = 1'b1,
  localparam int unsigned CH_W  = $clog2(NUM_CHAN),
  localparam int unsigned LVL_W = $clog2(NUM_CHAN + 1),
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][CH_W-1:0]   chan_i,
  input  logic [LVL_W-1:0]               level_i,
  output logic                           valid_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [CH_W-1:0]                chan_o
);
  logic [NUM_SRC-1:0] on_host;
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    if (FAST_HOST) begin : g_fast
      assign on_host[g] = 32'(chan_i[g]) < FAST_CHANS;
    end else begin : g_norm
      assign on_host[g] = 32'(chan_i[g]) >= FAST_CHANS;
    end
    assign elig[g] = pend_i[g] && on_host[g] && (LVL_W'(chan_i[g]) < level_i);
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    chan_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!valid_o || chan_i[i] < chan_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        chan_o  = chan_i[i];
      end
    end
  end

  // R9
  unmasked_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == LVL_W'(NUM_CHAN)) |-> (valid_o == |(pend_i & on_host)));
  // R6
  below_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (LVL_W'(chan_o) < level_i));
endmodule

// File: rtl/irq_nest_regs.sv
`timescale 1ns/1ps
module irq_nest_regs
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_CHAN = 16,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CHAN),
  localparam int unsigned LVL_W = $clog2(NUM_CHAN + 1),
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_wr_i,
  input  logic                         reg_rd_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  input  logic [NUM_SRC-1:0]           status_i,
  input  logic                         f_valid_i,
  input  logic [IDX_W-1:0]             f_idx_i,
  input  logic [CH_W-1:0]              f_chan_i,
  input  logic                         n_valid_i,
  input  logic [IDX_W-1:0]             n_idx_i,
  input  logic [CH_W-1:0]              n_chan_i,
  output logic [NUM_SRC-1:0]           enable_o,
  output logic [NUM_SRC-1:0][CH_W-1:0] map_o,
  output logic [NUM_SRC-1:0]           clr_o,
  output logic [LVL_W-1:0]             f_level_o,
  output logic [LVL_W-1:0]             n_level_o
);
  localparam logic [LVL_W-1:0] LVL_OPEN = LVL_W'(NUM_CHAN);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CHAN - 1);

  nest_mode_e               mode_q;
  logic [NUM_SRC-1:0]       en_q;
  logic [NUM_SRC-1:0][CH_W-1:0] map_q;
  logic [LVL_W-1:0]         glvl_q, flvl_q, nlvl_q;
  logic [DATA_W-1:0]        rdata_q, rd_mux;

  logic wr_ctrl, wr_en, wr_stat, wr_glvl, wr_flvl, wr_nlvl;
  logic ack_f, ack_n;
  logic raise_g_f, raise_g_n, raise_f, raise_n;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CTRL));
  assign wr_en   = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_EN));
  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STAT));
  assign wr_glvl = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_GLVL));
  assign wr_flvl = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_FLVL));
  assign wr_nlvl = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_NLVL));
  assign ack_f   = reg_rd_i && (reg_addr_i == ADDR_W'(OFS_FIDX));
  assign ack_n   = reg_rd_i && (reg_addr_i == ADDR_W'(OFS_NIDX));

  assign raise_g_f = ack_f && f_valid_i && (mode_q == NEST_GLOBAL);
  assign raise_g_n = ack_n && n_valid_i && (mode_q == NEST_GLOBAL);
  assign raise_f   = ack_f && f_valid_i && (mode_q == NEST_PERHOST);
  assign raise_n   = ack_n && n_valid_i && (mode_q == NEST_PERHOST);

  assign clr_o = wr_stat ? reg_wdata_i[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= NEST_OFF;
      en_q   <= '0;
      glvl_q <= LVL_OPEN;
      flvl_q <= LVL_OPEN;
      nlvl_q <= LVL_OPEN;
    end else begin
      if (wr_ctrl) mode_q <= nest_mode_e'(reg_wdata_i[1:0]);
      if (wr_en)   en_q   <= reg_wdata_i[NUM_SRC-1:0];
      if (wr_glvl)        glvl_q <= reg_wdata_i[LVL_W-1:0];
      else if (raise_g_f) glvl_q <= LVL_W'(f_chan_i);
      else if (raise_g_n) glvl_q <= LVL_W'(n_chan_i);
      if (wr_flvl)        flvl_q <= reg_wdata_i[LVL_W-1:0];
      else if (raise_f)   flvl_q <= LVL_W'(f_chan_i);
      if (wr_nlvl)        nlvl_q <= reg_wdata_i[LVL_W-1:0];
      else if (raise_n)   nlvl_q <= LVL_W'(n_chan_i);
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        map_q[g] <= CH_LAST;
      end else if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_MAP + g)) begin
        map_q[g] <= reg_wdata_i[CH_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      ADDR_W'(OFS_CTRL): rd_mux = DATA_W'(mode_q);
      ADDR_W'(OFS_EN):   rd_mux = DATA_W'(en_q);
      ADDR_W'(OFS_STAT): rd_mux = DATA_W'(status_i);
      ADDR_W'(OFS_GLVL): rd_mux = DATA_W'(glvl_q);
      ADDR_W'(OFS_FLVL): rd_mux = DATA_W'(flvl_q);
      ADDR_W'(OFS_NLVL): rd_mux = DATA_W'(nlvl_q);
      ADDR_W'(OFS_FIDX): rd_mux = f_valid_i ? DATA_W'(f_idx_i) : {1'b1, {(DATA_W-1){1'b0}}};
      ADDR_W'(OFS_NIDX): rd_mux = n_valid_i ? DATA_W'(n_idx_i) : {1'b1, {(DATA_W-1){1'b0}}};
      default: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (reg_addr_i == ADDR_W'(OFS_MAP + i)) rd_mux = DATA_W'(map_q[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  always_comb begin
    unique case (mode_q)
      NEST_OFF:     begin f_level_o = LVL_OPEN; n_level_o = LVL_OPEN; end
      NEST_PERHOST: begin f_level_o = flvl_q;   n_level_o = nlvl_q;   end
      default:      begin f_level_o = glvl_q;   n_level_o = glvl_q;   end
    endcase
  end

  assign reg_rdata_o = rdata_q;
  assign enable_o    = en_q;
  assign map_o       = map_q;

  // R6
  global_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_f && f_valid_i && mode_q == NEST_GLOBAL && !wr_glvl) |=> glvl_q == LVL_W'($past(f_chan_i)));
  // R7
  perhost_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_f && mode_q == NEST_PERHOST && !wr_nlvl) |=> $stable(nlvl_q));
  // R8
  manual_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == NEST_MANUAL && !wr_glvl) |=> $stable(glvl_q));
  // R5
  empty_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_n && !n_valid_i) |=> reg_rdata_o[DATA_W-1]);
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NUM_CHAN   = 16,
  parameter int unsigned FAST_CHANS = 2,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_irq_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               fast_irq_o,
  output logic               norm_irq_o
);
  localparam int unsigned CH_W  = $clog2(NUM_CHAN);
  localparam int unsigned LVL_W = $clog2(NUM_CHAN + 1);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]           status, enable, clr, pend;
  logic [NUM_SRC-1:0][CH_W-1:0] map;
  logic [LVL_W-1:0]             f_level, n_level;
  logic                         f_valid, n_valid;
  logic [IDX_W-1:0]             f_idx, n_idx;
  logic [CH_W-1:0]              f_chan, n_chan;

  irq_src_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i, .rst_ni, .src_i(src_irq_i), .clr_i(clr), .status_o(status)
  );

  assign pend = status & enable;

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .NUM_CHAN(NUM_CHAN), .FAST_CHANS(FAST_CHANS),
                  .FAST_HOST(1'b1)) u_pick_fast (
    .clk_i, .rst_ni, .pend_i(pend), .chan_i(map), .level_i(f_level),
    .valid_o(f_valid), .idx_o(f_idx), .chan_o(f_chan)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .NUM_CHAN(NUM_CHAN), .FAST_CHANS(FAST_CHANS),
                  .FAST_HOST(1'b0)) u_pick_norm (
    .clk_i, .rst_ni, .pend_i(pend), .chan_i(map), .level_i(n_level),
    .valid_o(n_valid), .idx_o(n_idx), .chan_o(n_chan)
  );

  irq_nest_regs #(.NUM_SRC(NUM_SRC), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .status_i(status),
    .f_valid_i(f_valid), .f_idx_i(f_idx), .f_chan_i(f_chan),
    .n_valid_i(n_valid), .n_idx_i(n_idx), .n_chan_i(n_chan),
    .enable_o(enable), .map_o(map), .clr_o(clr),
    .f_level_o(f_level), .n_level_o(n_level)
  );

  assign fast_irq_o = f_valid;
  assign norm_irq_o = n_valid;

  // R3
  fast_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_irq_o |-> |(status & enable));
  // R3
  norm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_irq_o |-> |(status & enable));
endmodule

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int FC = 2;
  localparam int AW = 8;
  localparam logic [31:0] NONE = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic fast_irq, norm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_nest_ctrl #(.NUM_SRC(NS), .NUM_CHAN(NC), .FAST_CHANS(FC), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fast_irq_o(fast_irq), .norm_irq_o(norm_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = AW'(a);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic expect_reg(string req, int a, logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
  endtask

  task automatic clean();
    wr_reg(0, 0);
    wr_reg(1, 0);
    wr_reg(2, 32'hFFFF_FFFF);
    wr_reg(3, NC); wr_reg(4, NC); wr_reg(5, NC);
  endtask

  task automatic t_reset();
    check("R1 fast low", {31'b0, fast_irq}, 0);
    check("R1 norm low", {31'b0, norm_irq}, 0);
    expect_reg("R1 ctrl", 0, 0);
    expect_reg("R1 enable", 1, 0);
    expect_reg("R1 status", 2, 0);
    expect_reg("R1 glvl", 3, NC);
    expect_reg("R1 flvl", 4, NC);
    expect_reg("R1 nlvl", 5, NC);
    expect_reg("R1 map0", 16, NC - 1);
  endtask

  task automatic t_status();
    clean();
    @(negedge clk); src[3] = 1'b1;
    repeat (2) @(negedge clk);
    expect_reg("R2 edge sets", 2, 32'h08);
    wr_reg(2, 32'h08);
    repeat (2) @(negedge clk);
    expect_reg("R2 held high no reset", 2, 32'h00);
    src[3] = 1'b0;
    pulse(3); pulse(5);
    expect_reg("R2 two set", 2, 32'h28);
    wr_reg(2, 32'h20);
    expect_reg("R2 W1C one bit", 2, 32'h08);
  endtask

  task automatic t_route();
    clean();
    wr_reg(16 + 3, 2);
    wr_reg(1, 32'h08);
    pulse(3);
    check("R3 normal routed fast", {31'b0, fast_irq}, 0);
    check("R3 normal routed norm", {31'b0, norm_irq}, 1);
    wr_reg(16 + 3, 1);
    check("R3 fast routed fast", {31'b0, fast_irq}, 1);
    check("R3 fast routed norm", {31'b0, norm_irq}, 0);
    wr_reg(1, 0);
    check("R3 disabled fast", {31'b0, fast_irq}, 0);
    expect_reg("R3 status kept", 2, 32'h08);
  endtask

  task automatic t_prio();
    clean();
    wr_reg(16 + 1, 3); wr_reg(16 + 2, 3); wr_reg(16 + 4, 2);
    wr_reg(1, 32'hFF);
    pulse(1); pulse(2); pulse(4);
    expect_reg("R4 R11 lowest channel", 7, 4);
    wr_reg(16 + 4, 3);
    expect_reg("R4 tie lowest index", 7, 1);
    wr_reg(16 + 5, 1); wr_reg(16 + 6, 0);
    pulse(5); pulse(6);
    expect_reg("R4 fast winner", 6, 6);
  endtask

  task automatic t_empty();
    clean();
    expect_reg("R5 fast empty", 6, NONE);
    expect_reg("R5 norm empty", 7, NONE);
  endtask

  task automatic t_global();
    clean();
    wr_reg(16 + 1, 1); wr_reg(16 + 2, 2); wr_reg(16 + 3, 3);
    wr_reg(1, 32'hFF);
    wr_reg(0, 1);
    pulse(2); pulse(3);
    check("R6 norm before ack", {31'b0, norm_irq}, 1);
    expect_reg("R6 norm ack", 7, 2);
    check("R6 norm masked", {31'b0, norm_irq}, 0);
    expect_reg("R6 glvl raised", 3, 2);
    pulse(1);
    check("R6 higher passes", {31'b0, fast_irq}, 1);
    expect_reg("R6 fast ack", 6, 1);
    check("R6 fast masked", {31'b0, fast_irq}, 0);
    wr_reg(3, 2);
    check("R10 fast restored", {31'b0, fast_irq}, 1);
    check("R10 norm still masked", {31'b0, norm_irq}, 0);
    wr_reg(3, NC);
    check("R10 norm restored", {31'b0, norm_irq}, 1);
  endtask

  task automatic t_perhost();
    clean();
    wr_reg(16 + 1, 1); wr_reg(16 + 2, 2);
    wr_reg(1, 32'hFF);
    wr_reg(0, 2);
    pulse(1); pulse(2);
    expect_reg("R7 fast ack", 6, 1);
    check("R7 fast masked", {31'b0, fast_irq}, 0);
    check("R7 norm untouched", {31'b0, norm_irq}, 1);
    expect_reg("R7 flvl", 4, 1);
    expect_reg("R7 nlvl", 5, NC);
    expect_reg("R7 norm ack", 7, 2);
    check("R7 norm masked", {31'b0, norm_irq}, 0);
    wr_reg(4, NC);
    check("R10 per-host restore", {31'b0, fast_irq}, 1);
  endtask

  task automatic t_manual();
    clean();
    wr_reg(16 + 2, 2);
    wr_reg(1, 32'hFF);
    wr_reg(0, 3);
    pulse(2);
    expect_reg("R8 ack", 7, 2);
    expect_reg("R8 glvl unchanged", 3, NC);
    check("R8 norm still up", {31'b0, norm_irq}, 1);
    wr_reg(3, 2);
    check("R8 software mask", {31'b0, norm_irq}, 0);
    wr_reg(3, 3);
    check("R8 software unmask", {31'b0, norm_irq}, 1);
  endtask

  task automatic t_off();
    clean();
    wr_reg(16 + 1, 1); wr_reg(16 + 2, 2);
    wr_reg(1, 32'hFF);
    wr_reg(3, 0); wr_reg(4, 0); wr_reg(5, 0);
    pulse(1); pulse(2);
    check("R9 fast ignores level", {31'b0, fast_irq}, 1);
    check("R9 norm ignores level", {31'b0, norm_irq}, 1);
    expect_reg("R9 ack", 6, 1);
    expect_reg("R9 glvl unchanged", 3, 0);
    expect_reg("R9 flvl unchanged", 4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_route();
    t_prio();
    t_empty();
    t_global();
    t_perhost();
    t_manual();
    t_off();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule